// File: doc/BRIEF.md
# Double-Write Indirect Register Bridge

This block is a register-bus slave that reaches two internal register buses through indirect windows. Each window has an address register, a data register and a control register. Software writes the target address into the address register twice in a row with the same value, and then either writes the data register once or reads it twice. A correct sequence becomes a single strobe on the internal bus. Any sequence that breaks the protocol is dropped, and it can also be flagged with an error response.

The "top" window lives at byte offsets 0x0 (address), 0x4 (data) and 0x8 (control). It reaches a 32-bit internal bus. The "controller" window lives at 0x10, 0x14 and 0x18 and reaches an internal bus with 8-bit values. Both internal buses take a 16-bit address. Each window has its own sequencing state machine:
- ST_IDLE, the reset state, holds no address.
- A first address write moves ST_IDLE to ST_HALF.
- A matching second address write moves ST_HALF to ST_ARMED. A different value stays in ST_HALF and becomes the new candidate.
- A data write in ST_ARMED issues an internal write and returns to ST_IDLE.
- A data read in ST_ARMED issues an internal read and moves to ST_RDWAIT.
- A data read in ST_RDWAIT returns the captured word and goes back to ST_IDLE.
- Any other data access is a violation and goes to ST_IDLE.
- An address write in any state goes to ST_HALF, or to ST_ARMED when it completes a matching pair.

Every bus access takes one cycle. Its read data and error flag appear in the cycle after the access. Internal strobes are one cycle wide and are registered. The internal read data is sampled during the strobe cycle.

Top module: `ibr_bridge`

## Requirements
- R1: Byte offsets bits [4:2] select the register: bit 4 picks the controller window (1) or the top window (0), and bits [3:2] pick address (0), data (1) or control (2). Encoding 3, and any access with a nonzero bit above bit 4, has no effect and reads as zero.
- R2: A window is armed only by two consecutive address-register writes with equal low 16 bits. A data access between them, or a differing second value, leaves it unarmed.
- R3: Only the low 16 bits of an address-register write are kept. They drive the internal address, and an address-register read returns them zero-extended.
- R4: A data-register write to an armed window produces exactly one internal write strobe, carrying the armed address and the write data, one cycle after the access.
- R5: The first data read of an armed window issues one internal read and returns the word captured by that window's previous internal read (zero after reset). The following data read returns the addressed register's value.
- R6: A data access to a window that is not armed, and a data write while a read is pending, produces no internal strobe and returns zero read data. It gives no error when error reporting is off.
- R7: Bit 15 of a window's control register enables error reporting. It reads back at bit 15, and when it is set, every R6 violation raises bus_err in the response cycle.
- R8: The controller window passes only the low 8 bits of write data to its internal bus and returns its read values zero-extended to 32 bits.
- R9: Accesses to one window never change the other window's sequence, address, control or captured data.
- R10: After reset all responses, strobes and control registers read zero and both windows are unarmed.
- R11: A completed data write or a completed read pair disarms the window, so a further data access needs a new address pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error response, one cycle after the access |
| top_addr | output | 16 | Top internal bus address |
| top_wdata | output | 32 | Top internal bus write data |
| top_wr | output | 1 | Top internal write strobe |
| top_rd | output | 1 | Top internal read strobe |
| top_rdata | input | 32 | Top internal read data, sampled while top_rd is high |
| ctl_addr | output | 16 | Controller internal bus address |
| ctl_wdata | output | 8 | Controller internal bus write data |
| ctl_wr | output | 1 | Controller internal write strobe |
| ctl_rd | output | 1 | Controller internal read strobe |
| ctl_rdata | input | 8 | Controller internal read data, sampled while ctl_rd is high |

## Verification
A window left in the wrong sequence state shows up on the next data access. A window wrongly armed produces a strobe where none should occur. A window wrongly unarmed drops the strobe, or sets bus_err when error reporting is on. Either failure is visible one or two cycles after the access. A bad capture or bad stale-value handling surfaces as a wrong word on the first or second read of the next pair. Cross-talk between windows shows as a strobe, an armed state or a captured word appearing in the window that was not accessed.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } ibr_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF   = 2'd1,
        ST_ARMED  = 2'd2,
        ST_RDWAIT = 2'd3
    } ibr_state_e;

    localparam int ERR_EN_BIT = 15;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sel_top,
    output logic              sel_ctl,
    output ibr_reg_e          reg_sel
);
    logic hi_ok;

    generate
        if (ADDR_W > 5) begin : g_hi
            assign hi_ok = (bus_addr[ADDR_W-1:5] == '0);
        end else begin : g_nohi
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign sel_top = bus_sel && hi_ok && !bus_addr[4];
    assign sel_ctl = bus_sel && hi_ok &&  bus_addr[4];
    assign reg_sel = ibr_reg_e'(bus_addr[3:2]);
endmodule

// File: rtl/ibr_channel.sv
module ibr_channel
    import ibr_pkg::*;
#(
    parameter int BUS_DW = 32,
    parameter int IA_W   = 16,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  ibr_reg_e          reg_sel,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rsp_data,
    output logic              rsp_err,
    output logic [IA_W-1:0]   ib_addr,
    output logic [DW-1:0]     ib_wdata,
    output logic              ib_wr,
    output logic              ib_rd,
    input  logic [DW-1:0]     ib_rdata
);
    ibr_state_e      state, nxt;
    logic [IA_W-1:0] pend_q;
    logic            err_en_q;
    logic [DW-1:0]   hold_q;
    logic [DW-1:0]   hold_now;
    logic            issue_wr, issue_rd, viol, give_hold;
    logic [BUS_DW-1:0] rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        issue_wr  = 1'b0;
        issue_rd  = 1'b0;
        viol      = 1'b0;
        give_hold = 1'b0;
        if (acc) begin
            unique case (reg_sel)
                SEL_ADDR: begin
                    if (wr) begin
                        nxt = (state == ST_HALF && wdata[IA_W-1:0] == pend_q)
                              ? ST_ARMED : ST_HALF;
                    end
                end
                SEL_DATA: begin
                    unique case (state)
                        ST_ARMED: begin
                            if (wr) begin
                                issue_wr = 1'b1;
                                nxt      = ST_IDLE;
                            end else begin
                                issue_rd  = 1'b1;
                                give_hold = 1'b1;
                                nxt       = ST_RDWAIT;
                            end
                        end
                        ST_RDWAIT: begin
                            nxt = ST_IDLE;
                            if (wr) viol = 1'b1;
                            else    give_hold = 1'b1;
                        end
                        default: begin
                            viol = 1'b1;
                            nxt  = ST_IDLE;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign hold_now = ib_rd ? ib_rdata : hold_q;

    always_comb begin
        rd_val = '0;
        if (acc && !wr) begin
            unique case (reg_sel)
                SEL_ADDR: rd_val[IA_W-1:0] = pend_q;
                SEL_DATA: if (give_hold) rd_val[DW-1:0] = hold_now;
                SEL_CTRL: rd_val[ERR_EN_BIT] = err_en_q;
                default:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            err_en_q <= 1'b0;
            hold_q   <= '0;
            ib_addr  <= '0;
            ib_wdata <= '0;
            ib_wr    <= 1'b0;
            ib_rd    <= 1'b0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else begin
            ib_wr    <= issue_wr;
            ib_rd    <= issue_rd;
            rsp_data <= rd_val;
            rsp_err  <= viol && err_en_q;
            if (issue_wr || issue_rd) ib_addr <= pend_q;
            if (issue_wr) ib_wdata <= wdata[DW-1:0];
            if (ib_rd) hold_q <= ib_rdata;
            if (acc && wr && reg_sel == SEL_ADDR) pend_q <= wdata[IA_W-1:0];
            if (acc && wr && reg_sel == SEL_CTRL) err_en_q <= wdata[ERR_EN_BIT];
        end
    end

    AST_WR_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_wr |-> $past(acc && wr && reg_sel == SEL_DATA)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ib_wr && ib_rd)); // R4
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ib_rd |=> !ib_rd); // R5
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(err_en_q)); // R7
    AST_ERR_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(acc && reg_sel == SEL_DATA)); // R6
    AST_ARM_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(state == ST_HALF)); // R2
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_DW = 32,
    parameter int IA_W   = 16,
    parameter int TOP_DW = 32,
    parameter int CTL_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              bus_err,
    output logic [IA_W-1:0]   top_addr,
    output logic [TOP_DW-1:0] top_wdata,
    output logic              top_wr,
    output logic              top_rd,
    input  logic [TOP_DW-1:0] top_rdata,
    output logic [IA_W-1:0]   ctl_addr,
    output logic [CTL_DW-1:0] ctl_wdata,
    output logic              ctl_wr,
    output logic              ctl_rd,
    input  logic [CTL_DW-1:0] ctl_rdata
);
    logic              sel_top, sel_ctl;
    ibr_reg_e          reg_sel;
    logic [BUS_DW-1:0] top_rsp, ctl_rsp;
    logic              top_err, ctl_err;

    ibr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .sel_top (sel_top),
        .sel_ctl (sel_ctl),
        .reg_sel (reg_sel)
    );

    ibr_channel #(.BUS_DW(BUS_DW), .IA_W(IA_W), .DW(TOP_DW)) u_top (
        .clk(clk), .rst_n(rst_n), .acc(sel_top), .wr(bus_wr), .reg_sel(reg_sel),
        .wdata(bus_wdata), .rsp_data(top_rsp), .rsp_err(top_err),
        .ib_addr(top_addr), .ib_wdata(top_wdata), .ib_wr(top_wr), .ib_rd(top_rd),
        .ib_rdata(top_rdata)
    );

    ibr_channel #(.BUS_DW(BUS_DW), .IA_W(IA_W), .DW(CTL_DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .acc(sel_ctl), .wr(bus_wr), .reg_sel(reg_sel),
        .wdata(bus_wdata), .rsp_data(ctl_rsp), .rsp_err(ctl_err),
        .ib_addr(ctl_addr), .ib_wdata(ctl_wdata), .ib_wr(ctl_wr), .ib_rd(ctl_rd),
        .ib_rdata(ctl_rdata)
    );

    assign bus_rdata = top_rsp | ctl_rsp;
    assign bus_err   = top_err | ctl_err;

    AST_TOP_STROBE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (top_wr || top_rd) |-> $past(bus_sel && !bus_addr[4])); // R9
    AST_CTL_STROBE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr || ctl_rd) |-> $past(bus_sel && bus_addr[4])); // R9
endmodule

// File: tb/ibr_bridge_test.sv
module ibr_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [15:0] top_addr, ctl_addr;
    logic [31:0] top_wdata, top_rdata;
    logic [7:0]  ctl_wdata, ctl_rdata;
    logic        top_wr, top_rd, ctl_wr, ctl_rd;

    int nchk = 0, nfail = 0;
    int tw_cnt = 0, tr_cnt = 0, cw_cnt = 0, cr_cnt = 0;
    logic [15:0] last_taddr = '0, last_caddr = '0;
    logic [31:0] tmem [16];
    logic [7:0]  cmem [16];
    logic [31:0] act, cap_t, cap_c;
    logic        er;

    always #4 clk = ~clk;

    ibr_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .top_addr(top_addr), .top_wdata(top_wdata),
        .top_wr(top_wr), .top_rd(top_rd), .top_rdata(top_rdata),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_wr(ctl_wr),
        .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata)
    );

    function automatic logic [31:0] init_t(int i);
        return 32'h1000_0000 + i * 32'h0101_0101;
    endfunction
    function automatic logic [7:0] init_c(int i);
        return 8'h30 + 8'(i);
    endfunction

    assign top_rdata = tmem[top_addr[3:0]];
    assign ctl_rdata = cmem[ctl_addr[3:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                tmem[i] <= init_t(i);
                cmem[i] <= init_c(i);
            end
        end else begin
            if (top_wr) begin tmem[top_addr[3:0]] <= top_wdata; tw_cnt <= tw_cnt + 1; last_taddr <= top_addr; end
            if (top_rd) begin tr_cnt <= tr_cnt + 1; last_taddr <= top_addr; end
            if (ctl_wr) begin cmem[ctl_addr[3:0]] <= ctl_wdata; cw_cnt <= cw_cnt + 1; last_caddr <= ctl_addr; end
            if (ctl_rd) begin cr_cnt <= cr_cnt + 1; last_caddr <= ctl_addr; end
        end
    end

    task automatic chk(string req, logic [31:0] a, logic [31:0] e);
        nchk++;
        if (a !== e) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", req, a, e);
        end
    endtask

    task automatic acc(input bit ch, input logic [1:0] r, input bit w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = {3'b000, ch, r, 2'b00}; bus_wdata = d;
        @(negedge clk);
        act = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic arm(input bit ch, input logic [31:0] a);
        acc(ch, 2'd0, 1'b1, a);
        acc(ch, 2'd0, 1'b1, a);
    endtask

    task automatic idle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int tw0, cw0, tr0, cr0;
        void'($urandom(32'd20240611));
        cap_t = '0; cap_c = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rdata", bus_rdata, 32'h0);
        chk("R10 err", {31'b0, bus_err}, 32'h0);
        chk("R10 strobes", {28'b0, top_wr, top_rd, ctl_wr, ctl_rd}, 32'h0);
        acc(1'b0, 2'd2, 1'b0, 0); chk("R10 top ctrl", act, 32'h0);
        acc(1'b1, 2'd2, 1'b0, 0); chk("R10 ctl ctrl", act, 32'h0);
        tw0 = tw_cnt;
        acc(1'b0, 2'd1, 1'b1, 32'h1); idle();
        chk("R10 unarmed after reset", tw_cnt - tw0, 0);

        // R1 R3 R4 write through top window
        arm(1'b0, 32'hFFFF_0005);
        acc(1'b0, 2'd0, 1'b0, 0); chk("R3 addr readback", act, 32'h0000_0005);
        arm(1'b0, 32'hFFFF_0005);
        tw0 = tw_cnt;
        acc(1'b0, 2'd1, 1'b1, 32'h1234_5678); idle();
        chk("R4 one write", tw_cnt - tw0, 1);
        chk("R3 internal addr", {16'h0, last_taddr}, 32'h5);
        chk("R4 data stored", tmem[5], 32'h1234_5678);

        // R5 read pairs
        arm(1'b0, 32'h5);
        acc(1'b0, 2'd1, 1'b0, 0); chk("R5 first read stale", act, cap_t);
        acc(1'b0, 2'd1, 1'b0, 0); chk("R5 second read", act, 32'h1234_5678);
        cap_t = 32'h1234_5678;
        arm(1'b0, 32'h7);
        acc(1'b0, 2'd1, 1'b0, 0); chk("R5 stale is previous capture", act, cap_t);
        acc(1'b0, 2'd1, 1'b0, 0); chk("R5 second read addr 7", act, init_t(7));
        cap_t = init_t(7);

        // R2 R6 broken sequences
        tw0 = tw_cnt; tr0 = tr_cnt;
        acc(1'b0, 2'd0, 1'b1, 32'h3);
        acc(1'b0, 2'd0, 1'b1, 32'h4);
        acc(1'b0, 2'd1, 1'b1, 32'hAAAA_AAAA);
        chk("R6 no error when disabled", {31'b0, er}, 32'h0);
        acc(1'b0, 2'd0, 1'b1, 32'h3);
        acc(1'b0, 2'd1, 1'b0, 0);
        chk("R6 unarmed read zero", act, 32'h0);
        acc(1'b0, 2'd0, 1'b1, 32'h3);
        acc(1'b0, 2'd1, 1'b1, 32'hBBBB_BBBB); idle();
        chk("R2 mismatch or interleave no strobe", (tw_cnt - tw0) + (tr_cnt - tr0), 0);
        chk("R2 memory untouched", tmem[3], init_t(3));

        // R7 error enable, R9 independence
        acc(1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF);
        acc(1'b0, 2'd2, 1'b0, 0); chk("R7 ctrl readback bit15", act, 32'h0000_8000);
        acc(1'b0, 2'd1, 1'b1, 32'h1); chk("R7 error raised", {31'b0, er}, 32'h1);
        acc(1'b1, 2'd1, 1'b1, 32'h1); chk("R9 other window no error", {31'b0, er}, 32'h0);
        arm(1'b0, 32'h9);
        acc(1'b0, 2'd1, 1'b0, 0);
        acc(1'b0, 2'd1, 1'b1, 32'h1); chk("R6 R7 write during pending read errs", {31'b0, er}, 32'h1);
        cap_t = init_t(9);
        acc(1'b0, 2'd3, 1'b1, 32'h1); chk("R1 unmapped slot no error", {31'b0, er}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h24;
        @(negedge clk); act = bus_rdata; bus_sel = 1'b0;
        chk("R1 high offset reads zero", act, 32'h0);
        acc(1'b0, 2'd2, 1'b1, 32'h0);

        // R11 disarm after completion
        arm(1'b0, 32'h2);
        tw0 = tw_cnt;
        acc(1'b0, 2'd1, 1'b1, 32'hCAFE_0001);
        acc(1'b0, 2'd1, 1'b1, 32'hCAFE_0002); idle();
        chk("R11 only one write", tw_cnt - tw0, 1);
        chk("R11 first value kept", tmem[2], 32'hCAFE_0001);

        // R8 controller window width
        cw0 = cw_cnt;
        arm(1'b1, 32'h0002);
        acc(1'b1, 2'd1, 1'b1, 32'hDEAD_BEEF); idle();
        chk("R8 one ctl write", cw_cnt - cw0, 1);
        chk("R8 truncated", {24'h0, cmem[2]}, 32'hEF);
        arm(1'b1, 32'h2);
        acc(1'b1, 2'd1, 1'b0, 0); chk("R8 stale ctl", act, cap_c);
        acc(1'b1, 2'd1, 1'b0, 0); chk("R8 zero-extended", act, 32'h0000_00EF);
        cap_c = 32'hEF;

        // R9 interleaved windows
        arm(1'b0, 32'hB);
        tw0 = tw_cnt; cr0 = cr_cnt;
        arm(1'b1, 32'h4);
        acc(1'b1, 2'd1, 1'b0, 0);
        acc(1'b1, 2'd1, 1'b0, 0); chk("R9 ctl read", act, {24'h0, init_c(4)});
        cap_c = {24'h0, init_c(4)};
        acc(1'b0, 2'd1, 1'b1, 32'h5555_0000); idle();
        chk("R9 top still armed", tw_cnt - tw0, 1);
        chk("R9 top addr kept", {16'h0, last_taddr}, 32'hB);
        chk("R9 one ctl read", cr_cnt - cr0, 1);

        // random write then read pairs
        for (int n = 0; n < 40; n++) begin
            bit          ch;
            logic [31:0] a, d, e;
            ch = 1'($urandom);
            a  = $urandom;
            d  = $urandom;
            e  = ch ? {24'h0, d[7:0]} : d;
            arm(ch, a);
            acc(ch, 2'd1, 1'b1, d);
            arm(ch, a);
            acc(ch, 2'd1, 1'b0, 0);
            chk(ch ? "R5 rand stale ctl" : "R5 rand stale top", act, ch ? cap_c : cap_t);
            acc(ch, 2'd1, 1'b0, 0);
            chk(ch ? "R8 rand ctl" : "R4 rand top", act, e);
            if (ch) cap_c = e; else cap_t = e;
            if (ch) chk("R3 rand ctl addr", {16'h0, last_caddr}, {16'h0, a[15:0]});
            else    chk("R3 rand top addr", {16'h0, last_taddr}, {16'h0, a[15:0]});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule